// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block owns the bookkeeping of a single-thread reorder buffer and decides, every cycle, what leaves it. Entries are allocated in program order at the tail. Each allocation receives the next sequence number, and the low bits of that number select the slot. Execution reports completion by sequence number. The controller retires completed entries from the head strictly in order, up to a fixed number per cycle. An entry flagged as non-speculative is held until it reaches the head, where the controller broadcasts its sequence number once so that earlier stages may issue it.

Back-end redirects are filtered by age against a register that tracks the youngest live sequence number. An accepted redirect is broadcast as a squash, which carries the surviving sequence number, a mispredict flag and a target. The youngest-live register then drops to that number, so later redirects from younger instructions are dropped. Squashed entries leave the tail at a limited rate over several cycles. Retirement and allocation wait until the removal finishes. A trap request freezes retirement and, after a fixed latency, squashes the entire buffer. A free-slot count with an update strobe goes back to the front end.

Top module: `rob_commit_ctl`

## Requirements
- R1: After reset no strobe is active, the free count equals DEPTH, allocation is offered and the first sequence number handed out is 0.
- R2: Each accepted allocation takes the next consecutive sequence number and lowers the free count by one. Allocation is refused while the buffer holds DEPTH entries.
- R3: In the cycle after the head entries are seen complete, up to COMMIT_W of them retire in order. Bit i of ret_valid marks sequence number ret_seq+i, and ret_valid is a thermometer code from bit 0.
- R4: Retirement stops at the first entry that is not complete. Younger complete entries wait for it.
- R5: An unreleased non-speculative entry at the head produces exactly one ns_valid pulse carrying its sequence number, one cycle after it becomes head. It retires only after completing, and no younger entry retires past it.
- R6: A redirect is accepted only when its sequence number lies inside the buffer and is older than the youngest-live register. An accepted redirect gives sq_valid in the next cycle, with its sequence number, mispredict flag and target.
- R7: After an accepted redirect, the youngest-live value is that redirect's sequence number. A later redirect from the same or a younger instruction is ignored, while an older one is accepted, even during removal.
- R8: Squashed entries leave the tail at no more than SQUASH_W per cycle. Retirement and allocation are blocked until removal ends, and the next allocation reuses squash number + 1.
- R9: free_upd pulses in exactly those cycles in which free_cnt takes a new value.
- R10: A trap request blocks retirement and allocation. TRAP_LAT cycles later it broadcasts a squash of everything (sequence head−1, mispredict 0, target 0), and all entries then drain at the squash rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Allocation request |
| disp_nonspec | input | 1 | Allocated entry is non-speculative |
| disp_ready | output | 1 | Allocation accepted this cycle |
| disp_seq | output | SEQ_W | Sequence number for the offered allocation |
| cmpl_valid | input | 1 | Completion report |
| cmpl_seq | input | SEQ_W | Sequence number that completed |
| redir_valid | input | 1 | Redirect request |
| redir_seq | input | SEQ_W | Sequence number of the redirecting instruction |
| redir_mispredict | input | 1 | Redirect is a branch mispredict |
| redir_target | input | TGT_W | Redirect target address |
| trap_req | input | 1 | Trap request, squashes everything after latency |
| ret_valid | output | COMMIT_W | Retire strobes, thermometer coded |
| ret_seq | output | SEQ_W | Sequence number of the oldest retired entry |
| ns_valid | output | 1 | Non-speculative release pulse |
| ns_seq | output | SEQ_W | Released sequence number |
| sq_valid | output | 1 | Squash broadcast |
| sq_seq | output | SEQ_W | Youngest surviving sequence number |
| sq_mispredict | output | 1 | Squash caused by a mispredict |
| sq_target | output | TGT_W | Redirect target |
| free_upd | output | 1 | Free count changed |
| free_cnt | output | $clog2(DEPTH)+1 | Free slots |

## Verification
Completion is driven in order, in reverse order, and with holes, so that a width-limited burst, a stop at a gap and a one-per-cycle trickle each show up as a distinct retire pattern. Redirects are sent that lie past the tail, match the youngest entry, precede the head, come from a younger instruction during removal and from an older one during removal. Only the older, in-range ones may produce a squash. The removal length is picked to need two cycles, so the per-cycle rate and the reuse of sequence numbers become visible. The trap path is driven with a completed head entry, to show that retirement stays frozen until the squash-all.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {
    RC_RUN    = 2'd0,
    RC_SQUASH = 2'd1,
    RC_TRAP   = 2'd2
  } rc_state_e;
endpackage

// File: rtl/rcc_flags.sv
module rcc_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             alloc_ns,
  input  logic             done_en,
  input  logic [IDX_W-1:0] done_idx,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] head_idx,
  output logic [CW-1:0]    win_done,
  output logic [CW-1:0]    win_ns,
  output logic [CW-1:0]    win_rel
);
  logic [DEPTH-1:0] done_q, ns_q, rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      ns_q   <= '0;
      rel_q  <= '0;
    end else begin
      if (done_en) done_q[done_idx] <= 1'b1;
      if (rel_en)  rel_q[head_idx]  <= 1'b1;
      if (alloc_en) begin
        done_q[alloc_idx] <= 1'b0;
        rel_q[alloc_idx]  <= 1'b0;
        ns_q[alloc_idx]   <= alloc_ns;
      end
    end
  end

  for (genvar g = 0; g < CW; g++) begin : g_win
    logic [IDX_W-1:0] slot;
    assign slot        = head_idx + IDX_W'(g);
    assign win_done[g] = done_q[slot];
    assign win_ns[g]   = ns_q[slot];
    assign win_rel[g]  = rel_q[slot];
  end
endmodule

// File: rtl/rcc_retire_sel.sv
module rcc_retire_sel #(
  parameter int CW    = 4,
  parameter int CNT_W = 5,
  localparam int KW   = $clog2(CW + 1)
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic [CW-1:0]    win_done,
  input  logic [CW-1:0]    win_ns,
  input  logic [CW-1:0]    win_rel,
  output logic [KW-1:0]    k,
  output logic [CW-1:0]    mask
);
  always_comb begin
    logic stop;
    stop = !enable;
    k    = '0;
    mask = '0;
    for (int i = 0; i < CW; i++) begin
      if (!stop && (CNT_W'(i) < count) && win_done[i] && (!win_ns[i] || win_rel[i])) begin
        k       = k + KW'(1);
        mask[i] = 1'b1;
      end else begin
        stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcc_age_filter.sv
module rcc_age_filter #(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic [CNT_W-1:0] count,
  input  logic             allow,
  input  logic             req_valid,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic             load_en,
  input  logic [SEQ_W-1:0] load_seq,
  output logic             accept,
  output logic [SEQ_W-1:0] youngest
);
  logic [SEQ_W-1:0] req_off, yng_off, cnt_ext;

  assign cnt_ext = SEQ_W'(count);
  assign req_off = req_seq - head_seq;
  assign yng_off = youngest - head_seq;
  assign accept  = allow && req_valid && (req_off < cnt_ext)
                   && (yng_off < cnt_ext) && (req_off < yng_off);

  always_ff @(posedge clk) begin
    if (rst)          youngest <= '1;
    else if (accept)  youngest <= req_seq;
    else if (load_en) youngest <= load_seq;
  end

  p_youngest_drop_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> youngest == $past(req_seq));
endmodule

// File: rtl/rob_commit_ctl.sv
module rob_commit_ctl
  import rcc_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int COMMIT_W = 4,
  parameter int SQUASH_W = 2,
  parameter int SEQ_W    = 16,
  parameter int TGT_W    = 32,
  parameter int TRAP_LAT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     disp_valid,
  input  logic                     disp_nonspec,
  output logic                     disp_ready,
  output logic [SEQ_W-1:0]         disp_seq,
  input  logic                     cmpl_valid,
  input  logic [SEQ_W-1:0]         cmpl_seq,
  input  logic                     redir_valid,
  input  logic [SEQ_W-1:0]         redir_seq,
  input  logic                     redir_mispredict,
  input  logic [TGT_W-1:0]         redir_target,
  input  logic                     trap_req,
  output logic [COMMIT_W-1:0]      ret_valid,
  output logic [SEQ_W-1:0]         ret_seq,
  output logic                     ns_valid,
  output logic [SEQ_W-1:0]         ns_seq,
  output logic                     sq_valid,
  output logic [SEQ_W-1:0]         sq_seq,
  output logic                     sq_mispredict,
  output logic [TGT_W-1:0]         sq_target,
  output logic                     free_upd,
  output logic [$clog2(DEPTH):0]   free_cnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam int KW    = $clog2(COMMIT_W + 1);
  localparam int TW    = $clog2(TRAP_LAT + 1);

  rc_state_e        state;
  logic [SEQ_W-1:0] head_seq, tail_seq, sq_tgt_q, youngest;
  logic [TW-1:0]    trap_cnt;
  logic [CNT_W-1:0] count, count_next;
  logic [SEQ_W-1:0] head_next, tail_next, remaining, rm;
  logic [COMMIT_W-1:0] win_done, win_ns, win_rel, ret_mask;
  logic [KW-1:0]    k;
  logic disp_fire, cmpl_in, take_trap, trap_fire, allow, accept, run_go, release_hd;

  assign count      = CNT_W'(tail_seq - head_seq);
  assign disp_ready = (state == RC_RUN) && (count < CNT_W'(DEPTH));
  assign disp_seq   = tail_seq;
  assign disp_fire  = disp_valid && disp_ready;
  assign cmpl_in    = cmpl_valid && ((cmpl_seq - head_seq) < SEQ_W'(count));
  assign take_trap  = (state == RC_RUN) && trap_req;
  assign trap_fire  = (state == RC_TRAP) && (trap_cnt == TW'(TRAP_LAT - 1));
  assign allow      = ((state == RC_RUN) || (state == RC_SQUASH)) && !take_trap;
  assign run_go     = (state == RC_RUN) && !accept;
  assign release_hd = run_go && (count != '0) && win_ns[0] && !win_rel[0];

  rcc_flags #(.DEPTH(DEPTH), .CW(COMMIT_W), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst(rst),
    .alloc_en(disp_fire), .alloc_idx(tail_seq[IDX_W-1:0]), .alloc_ns(disp_nonspec),
    .done_en(cmpl_in), .done_idx(cmpl_seq[IDX_W-1:0]),
    .rel_en(release_hd), .head_idx(head_seq[IDX_W-1:0]),
    .win_done(win_done), .win_ns(win_ns), .win_rel(win_rel)
  );

  rcc_retire_sel #(.CW(COMMIT_W), .CNT_W(CNT_W)) u_sel (
    .enable(run_go), .count(count),
    .win_done(win_done), .win_ns(win_ns), .win_rel(win_rel),
    .k(k), .mask(ret_mask)
  );

  rcc_age_filter #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_age (
    .clk(clk), .rst(rst), .head_seq(head_seq), .count(count),
    .allow(allow), .req_valid(redir_valid), .req_seq(redir_seq),
    .load_en(disp_fire || trap_fire),
    .load_seq(trap_fire ? head_seq - SEQ_W'(1) : tail_seq),
    .accept(accept), .youngest(youngest)
  );

  // tail-side removal while squashing
  assign remaining = tail_seq - sq_tgt_q - SEQ_W'(1);
  assign rm = (state != RC_SQUASH) ? '0 :
              (remaining < SEQ_W'(SQUASH_W)) ? remaining : SEQ_W'(SQUASH_W);

  always_comb begin
    head_next = head_seq + SEQ_W'(k);
    if (disp_fire) tail_next = tail_seq + SEQ_W'(1);
    else           tail_next = tail_seq - rm;
    count_next = CNT_W'(tail_next - head_next);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RC_RUN;
      head_seq <= '0;
      tail_seq <= '0;
      sq_tgt_q <= '0;
      trap_cnt <= '0;
    end else begin
      head_seq <= head_next;
      tail_seq <= tail_next;
      unique case (state)
        RC_RUN: begin
          if (take_trap) begin
            state    <= RC_TRAP;
            trap_cnt <= '0;
          end else if (accept) begin
            state    <= RC_SQUASH;
            sq_tgt_q <= redir_seq;
          end
        end
        RC_TRAP: begin
          if (trap_fire) begin
            state    <= RC_SQUASH;
            sq_tgt_q <= head_seq - SEQ_W'(1);
          end else begin
            trap_cnt <= trap_cnt + TW'(1);
          end
        end
        RC_SQUASH: begin
          if (accept)                sq_tgt_q <= redir_seq;
          else if (remaining == rm)  state    <= RC_RUN;
        end
        default: state <= RC_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid     <= '0;
      ret_seq       <= '0;
      ns_valid      <= 1'b0;
      ns_seq        <= '0;
      sq_valid      <= 1'b0;
      sq_seq        <= '0;
      sq_mispredict <= 1'b0;
      sq_target     <= '0;
      free_upd      <= 1'b0;
      free_cnt      <= CNT_W'(DEPTH);
    end else begin
      ret_valid     <= ret_mask;
      ret_seq       <= head_seq;
      ns_valid      <= release_hd;
      ns_seq        <= head_seq;
      sq_valid      <= accept || trap_fire;
      sq_seq        <= accept ? redir_seq : head_seq - SEQ_W'(1);
      sq_mispredict <= accept && redir_mispredict;
      sq_target     <= accept ? redir_target : '0;
      free_upd      <= (count_next != count);
      free_cnt      <= CNT_W'(DEPTH) - count_next;
    end
  end

  p_occupancy_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_head_advance_r3: assert property (@(posedge clk) disable iff (rst)
    ret_valid[0] |-> head_seq == ret_seq + SEQ_W'($countones(ret_valid)));
  p_release_at_head_r5: assert property (@(posedge clk) disable iff (rst)
    ns_valid |-> ns_seq == head_seq);
  p_youngest_tail_r7: assert property (@(posedge clk) disable iff (rst)
    (state == RC_RUN) |-> youngest == tail_seq - SEQ_W'(1));
  p_squash_rate_r8: assert property (@(posedge clk) disable iff (rst)
    (state == RC_SQUASH) |=> (SEQ_W'($past(tail_seq) - tail_seq) <= SEQ_W'(SQUASH_W)));
  p_free_change_r9: assert property (@(posedge clk) disable iff (rst)
    free_upd |-> free_cnt != $past(free_cnt));
  p_frozen_retire_r10: assert property (@(posedge clk) disable iff (rst)
    (ret_valid != '0) |-> $past(state) == RC_RUN);
endmodule

// File: tb/tb_rob_commit_ctl.sv
module tb_rob_commit_ctl;
  localparam int DEPTH = 16, CW = 4, SW = 2, SEQ_W = 16, TGT_W = 32, TL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic disp_valid = 0, disp_nonspec = 0, cmpl_valid = 0, redir_valid = 0;
  logic redir_mispredict = 0, trap_req = 0;
  logic [SEQ_W-1:0] cmpl_seq = '0, redir_seq = '0;
  logic [TGT_W-1:0] redir_target = '0;
  logic disp_ready, ns_valid, sq_valid, sq_mispredict, free_upd;
  logic [SEQ_W-1:0] disp_seq, ret_seq, ns_seq, sq_seq;
  logic [TGT_W-1:0] sq_target;
  logic [CW-1:0] ret_valid;
  logic [$clog2(DEPTH):0] free_cnt;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  rob_commit_ctl #(.DEPTH(DEPTH), .COMMIT_W(CW), .SQUASH_W(SW), .SEQ_W(SEQ_W),
                   .TGT_W(TGT_W), .TRAP_LAT(TL)) dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      n_bad = n_bad + 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic disp(input logic ns);
    disp_valid = 1; disp_nonspec = ns; step(); disp_valid = 0; disp_nonspec = 0;
  endtask

  task automatic cmpl(input int s);
    cmpl_valid = 1; cmpl_seq = SEQ_W'(s); step(); cmpl_valid = 0;
  endtask

  task automatic redir(input int s, input logic mis, input int tgt);
    redir_valid = 1; redir_seq = SEQ_W'(s); redir_mispredict = mis;
    redir_target = TGT_W'(tgt); step(); redir_valid = 0; redir_mispredict = 0;
  endtask

  task automatic t_reset();
    check("R1 ret", ret_valid, 0);
    check("R1 free", free_cnt, DEPTH);
    check("R1 ready", disp_ready, 1);
    check("R1 seq", disp_seq, 0);
    check("R1 sq", sq_valid, 0);
    check("R1 ns", ns_valid, 0);
  endtask

  task automatic t_gap_retire();
    for (int i = 0; i < 6; i++) begin
      check("R2 seq", disp_seq, i);
      disp(0);
      check("R2 free", free_cnt, DEPTH - 1 - i);
      check("R9 upd", free_upd, 1);
    end
    cmpl(1); check("R4 hole", ret_valid, 0); check("R9 idle", free_upd, 0);
    cmpl(2); check("R4 hole", ret_valid, 0);
    cmpl(0); check("R4 hole", ret_valid, 0);
    cmpl(4); check("R3 burst", ret_valid, 4'b0111); check("R3 seq", ret_seq, 0);
    step();  check("R4 wait", ret_valid, 0);
    cmpl(3); check("R4 wait", ret_valid, 0);
    step();  check("R4 resume", ret_valid, 4'b0011); check("R3 seq", ret_seq, 3);
    cmpl(5); check("R4 none", ret_valid, 0);
    step();  check("R3 last", ret_valid, 4'b0001); check("R2 free", free_cnt, DEPTH);
  endtask

  task automatic t_width();
    for (int i = 0; i < 6; i++) disp(0);
    for (int s = 11; s >= 6; s--) begin
      cmpl(s); check("R4 reverse", ret_valid, 0);
    end
    step(); check("R3 width", ret_valid, 4'b1111); check("R3 seq", ret_seq, 6);
    check("R3 free", free_cnt, 14);
    step(); check("R3 rest", ret_valid, 4'b0011); check("R3 seq", ret_seq, 10);
    check("R3 free", free_cnt, DEPTH);
  endtask

  task automatic t_nonspec();
    disp(0); disp(1); disp(0);            // 12, 13(ns), 14
    cmpl(12); check("R5 ns", ns_valid, 0);
    cmpl(14); check("R5 ret12", ret_valid, 1); check("R5 ns", ns_valid, 0);
    step(); check("R5 release", ns_valid, 1); check("R5 nsseq", ns_seq, 13);
    check("R5 hold", ret_valid, 0);
    step(); check("R5 once", ns_valid, 0); check("R5 block", ret_valid, 0);
    cmpl(13); check("R5 block", ret_valid, 0);
    step(); check("R5 retire", ret_valid, 4'b0011); check("R5 seq", ret_seq, 13);
    check("R5 free", free_cnt, DEPTH);
  endtask

  task automatic t_redirect();
    for (int i = 0; i < 5; i++) disp(0);  // 15..19
    redir(20, 1, 1); check("R6 past tail", sq_valid, 0);
    redir(19, 1, 1); check("R6 youngest", sq_valid, 0);
    redir(14, 1, 1); check("R6 before head", sq_valid, 0);
    redir(16, 1, 'h1234);
    check("R6 sq", sq_valid, 1); check("R6 sqseq", sq_seq, 16);
    check("R6 mis", sq_mispredict, 1); check("R6 tgt", sq_target, 'h1234);
    check("R8 ready", disp_ready, 0); check("R8 free", free_cnt, 11);
    redir(17, 1, 5); check("R7 younger", sq_valid, 0); check("R8 rate", free_cnt, 13);
    redir(15, 0, 'h40);
    check("R7 older", sq_valid, 1); check("R7 seq", sq_seq, 15);
    check("R7 mis", sq_mispredict, 0); check("R7 tgt", sq_target, 'h40);
    check("R8 rate", free_cnt, 14);
    step(); check("R8 done", free_cnt, 15); check("R8 ready", disp_ready, 1);
    check("R8 reuse", disp_seq, 16); check("R7 quiet", sq_valid, 0);
    cmpl(15);
    step(); check("R8 retire", ret_valid, 1); check("R8 seq", ret_seq, 15);
  endtask

  task automatic t_trap();
    disp(0); disp(0); disp(0);            // 16..18
    trap_req = 1; step(); trap_req = 0;
    check("R10 ready", disp_ready, 0); check("R10 sq", sq_valid, 0);
    cmpl(16); check("R10 frozen", ret_valid, 0);
    step(); check("R10 frozen", ret_valid, 0); check("R10 sq", sq_valid, 0);
    step(); check("R10 frozen", ret_valid, 0); check("R10 sq", sq_valid, 0);
    step(); check("R10 sqall", sq_valid, 1); check("R10 seq", sq_seq, 15);
    check("R10 mis", sq_mispredict, 0); check("R10 tgt", sq_target, 0);
    check("R10 ret", ret_valid, 0);
    step(); check("R10 drain", free_cnt, 15);
    step(); check("R10 drain", free_cnt, DEPTH); check("R10 ready", disp_ready, 1);
    check("R10 seq", disp_seq, 16);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) disp(0);
    check("R2 full", disp_ready, 0); check("R2 free", free_cnt, 0);
    disp(0); check("R2 refused", free_cnt, 0); check("R2 seq", disp_seq, 32);
    check("R9 still", free_upd, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cmpl(16 + i);
      if (i > 0) begin
        check("R3 trickle", ret_valid, 1); check("R3 seq", ret_seq, 16 + i - 1);
      end
    end
    step(); check("R3 trickle", ret_valid, 1); check("R3 seq", ret_seq, 31);
    check("R2 free", free_cnt, DEPTH);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_gap_retire();
    t_width();
    t_nonspec();
    t_redirect();
    t_trap();
    t_full();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule